// File: doc/BRIEF.md
# Composite Memory Chip-Select Merger

This block produces one additional active-low chip-select that asserts whenever any chosen member of a set of four existing active-low memory strobes asserts. The four strobes serve program memory, data memory, byte memory and I/O space. A single external device can then answer to more than one space. For example, one RAM can serve both program and data memory, with one of the individual strobes used as an extra address line. The merged select is formed combinationally from the incoming strobes, so its timing is the same as theirs.

A small configuration register, loaded through a synchronous write port, chooses which strobes feed the merged output. The same register holds a separate enable for the byte-memory strobe, which can silence that strobe at the pin. After reset the byte strobe is live and the merged select ignores byte accesses, so a boot memory on the byte strobe is used first. Software can later turn off the byte strobe and route byte accesses to the merged select, which switches in a second memory. When the external bus is granted to another master, both outputs are released high.

Top module: `comp_select_top`

## Requirements
- R1: When mask bit i is 1, `busGrant` is 0 and strobe i of `selInN` is low, `compSelN` is low. The bit order is program=0, data=1, byte=2, I/O=3.
- R2: `compSelN` is high whenever every strobe whose mask bit is 1 is high. This includes the case where the mask is all zeros.
- R3: After reset the mask is 4'b1011, so program, data and I/O are enabled and byte is disabled, and the byte-strobe enable is 1.
- R4: On a rising clock edge with `cfgWe` high, the mask loads from `cfgWrData[3:0]` and the byte-strobe enable loads from `cfgWrData[4]`. The new values take effect after that edge. Without `cfgWe`, the configuration holds.
- R5: While `busGrant` is high, `compSelN` and `byteSelOutN` are both high, whatever the strobes and the configuration are.
- R6: When the byte-strobe enable is 0, `byteSelOutN` is high. When it is 1 and `busGrant` is 0, `byteSelOutN` equals `selInN[2]`.
- R7: Both outputs respond to strobe and grant changes in the same cycle. There is no register between the inputs and the outputs.
- R8: Boot-then-swap works as follows. From reset, a byte access drives `byteSelOutN` low and leaves `compSelN` high. After writing byte enable 0 and setting mask bit 2, the same access leaves `byteSelOutN` high and drives `compSelN` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgWrData | input | 5 | Bits 3:0 are the mask; bit 4 is the byte-strobe enable |
| selInN | input | 4 | Active-low strobes: program, data, byte, I/O (bits 0 to 3) |
| busGrant | input | 1 | High while the external bus is granted away |
| compSelN | output | 1 | Merged active-low chip-select |
| byteSelOutN | output | 1 | Byte strobe after the enable gate, active low |

## Verification
The datapath assertions check four properties on every cycle. They confirm that an enabled low strobe pulls the merged select low, that the merged select never asserts without an enabled low strobe, that a grant releases both outputs, and that a disabled byte strobe stays high. The control assertions check that the configuration holds without a write and loads exactly on a write. Only the bench scenarios can show some behaviours. These are the reset defaults seen at the pins, the same-cycle response with no clock edge between a strobe change and the output, the full sweep of every mask, byte enable, strobe pattern and grant value, and the ordered boot-then-swap sequence.

// File: rtl/comp_select_pkg.sv
package comp_select_pkg;
  localparam int NUM_SEL = 4;
  localparam int IDX_PROG = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_BYTE = 2;
  localparam int IDX_IO = 3;
  localparam int CFG_W = NUM_SEL + 1;

  typedef struct packed {
    logic [NUM_SEL-1:0] mask;
    logic byteOn;
  } selCfg_t;
endpackage

// File: rtl/comp_select_cfg.sv
module comp_select_cfg
  import comp_select_pkg::*;
#(
  parameter logic [NUM_SEL-1:0] RESET_MASK = 4'b1011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWrData,
  output selCfg_t          cfg
);
  selCfg_t cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.mask   <= RESET_MASK;
      cfgQ.byteOn <= 1'b1;
    end else if (cfgWe) begin
      cfgQ.mask   <= cfgWrData[NUM_SEL-1:0];
      cfgQ.byteOn <= cfgWrData[NUM_SEL];
    end
  end

  assign cfg = cfgQ;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfg)); // R4
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (cfg == {$past(cfgWrData[NUM_SEL-1:0]), $past(cfgWrData[NUM_SEL])})); // R4
endmodule

// File: rtl/comp_select_path.sv
module comp_select_path
  import comp_select_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  selCfg_t            cfg,
  input  logic [NUM_SEL-1:0] selInN,
  input  logic               busGrant,
  output logic               compSelN,
  output logic               byteSelOutN
);
  logic [NUM_SEL-1:0] hit;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_hit
    assign hit[g] = cfg.mask[g] & ~selInN[g];
  end

  always_comb begin
    compSelN    = busGrant | ~(|hit);
    byteSelOutN = busGrant | ~cfg.byteOn | selInN[IDX_BYTE];
  end

  AST_PROG_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mask[IDX_PROG] && !selInN[IDX_PROG] && !busGrant) |-> !compSelN); // R1
  AST_IO_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mask[IDX_IO] && !selInN[IDX_IO] && !busGrant) |-> !compSelN); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (&(selInN | ~cfg.mask)) |-> compSelN); // R2
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> (compSelN && byteSelOutN)); // R5
  AST_BYTE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.byteOn |-> byteSelOutN); // R6
endmodule

// File: rtl/comp_select_top.sv
module comp_select_top
  import comp_select_pkg::*;
#(
  parameter logic [NUM_SEL-1:0] RESET_MASK = 4'b1011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [NUM_SEL-1:0] selInN,
  input  logic             busGrant,
  output logic             compSelN,
  output logic             byteSelOutN
);
  selCfg_t cfg;

  comp_select_cfg #(.RESET_MASK(RESET_MASK)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWrData(cfgWrData), .cfg(cfg)
  );

  comp_select_path u_path (
    .clk(clk), .rstN(rstN), .cfg(cfg), .selInN(selInN), .busGrant(busGrant),
    .compSelN(compSelN), .byteSelOutN(byteSelOutN)
  );
endmodule

// File: tb/comp_select_top_tb.sv
module comp_select_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgWrData = '0;
  logic [3:0] selInN = 4'hF;
  logic busGrant = 1'b0;
  logic compSelN, byteSelOutN;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  comp_select_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWrData(cfgWrData),
    .selInN(selInN), .busGrant(busGrant),
    .compSelN(compSelN), .byteSelOutN(byteSelOutN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b (mask-in sel=%b grant=%b)",
               req, act, exp, selInN, busGrant);
    end
  endtask

  task automatic writeCfg(input logic [3:0] m, input logic bOn);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWrData = {bOn, m};
    @(negedge clk);
    cfgWe = 1'b0;
    cfgWrData = '0;
  endtask

  function automatic logic expComp(input logic [3:0] m, input logic [3:0] s, input logic g);
    return g | ~(|(m & ~s));
  endfunction

  function automatic logic expByte(input logic bOn, input logic [3:0] s, input logic g);
    return g | ~bOn | s[2];
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3: reset defaults seen at the pins, mask 1011 and byte enabled
    for (int s = 0; s < 16; s++) begin
      selInN = s[3:0];
      #1;
      check("R3 comp", compSelN, expComp(4'b1011, s[3:0], 1'b0));
      check("R3 byte", byteSelOutN, expByte(1'b1, s[3:0], 1'b0));
    end
    selInN = 4'hF;
    // R8: boot-then-swap
    @(negedge clk);
    selInN = 4'b1011;
    #1;
    check("R8 boot byte", byteSelOutN, 1'b0);
    check("R8 boot comp", compSelN, 1'b1);
    selInN = 4'hF;
    writeCfg(4'b1111, 1'b0);
    selInN = 4'b1011;
    #1;
    check("R8 swap byte", byteSelOutN, 1'b1);
    check("R8 swap comp", compSelN, 1'b0);
    selInN = 4'hF;
    // R4: a write is not visible before the edge
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWrData = 5'b1_0000;
    selInN = 4'b1110;
    #1;
    check("R4 pre-edge", compSelN, 1'b0);
    @(negedge clk);
    cfgWe = 1'b0;
    #1;
    check("R4 post-edge", compSelN, 1'b1);
    // R4: configuration holds with write enable low
    cfgWrData = 5'b0_1111;
    repeat (2) @(negedge clk);
    #1;
    check("R4 hold", compSelN, 1'b1);
    check("R4 hold byte", byteSelOutN, 1'b1);
    selInN = 4'hF;
    // R1 R2 R5 R6 R7: exhaustive sweep over every configuration
    for (int c = 0; c < 32; c++) begin
      writeCfg(c[3:0], c[4]);
      for (int p = 0; p < 32; p++) begin
        selInN = p[3:0];
        busGrant = p[4];
        #1;  // no clock edge between stimulus and sample: R7
        if (!p[4] && (|(c[3:0] & ~p[3:0])))
          check("R1 comp", compSelN, expComp(c[3:0], p[3:0], p[4]));
        else if (p[4])
          check("R5 comp", compSelN, 1'b1);
        else
          check("R2 comp", compSelN, 1'b1);
        if (p[4])
          check("R5 byte", byteSelOutN, 1'b1);
        else
          check("R6 byte", byteSelOutN, expByte(c[4], p[3:0], 1'b0));
      end
      selInN = 4'hF;
      busGrant = 1'b0;
    end
    // R7: a strobe edge mid-cycle reaches the output within the same cycle
    writeCfg(4'b0010, 1'b1);
    @(posedge clk);
    #3;
    selInN = 4'b1101;
    #1;
    check("R7 mid-cycle", compSelN, 1'b0);
    selInN = 4'hF;
    #1;
    check("R7 release", compSelN, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule